// File: doc/BRIEF.md
# 8-bit ALU with status register

This block is the arithmetic and logic unit of a small 8-bit controller core together with the status register that holds its flags. Each cycle it takes an operation code, the current accumulator, a second operand and the B register, and it produces the new accumulator value and the new B value combinationally. The carry, auxiliary carry and overflow flags it produces are stored in the status byte at the next rising clock edge. The surrounding core writes the returned values back into its own accumulator and B registers.

The status byte also holds a general-purpose user flag, a second user bit and a two-bit register-bank selector. Software changes these through a status-write port. The parity bit is not stored. It is always the parity of the accumulator presented at the input, so it follows every change of the accumulator without a cycle of delay. The bank selector is also decoded into the base byte address of the selected bank of eight working registers.

Top module: `alu8_status`

## Requirements
- R1: The status byte `psw_o` is laid out as bit 7 CY, bit 6 AC, bit 5 F0, bits 4:3 bank select (bit 4 high), bit 2 OV, bit 1 user bit, bit 0 P. Reset clears bits 7:1.
- R2: `psw_o[0]` is 1 exactly when `acc_i` holds an odd number of ones. It is combinational and valid in every cycle.
- R3: Op 1 (add) gives A+opnd and op 2 (add with carry) gives A+opnd+CY, modulo 256. At the clock edge CY takes the carry out of bit 7, AC the carry out of bit 3, and OV the signed overflow.
- R4: Op 3 (subtract with borrow) gives A−opnd−CY modulo 256. At the clock edge CY takes the borrow out of bit 7, AC the borrow out of bit 3, and OV the signed overflow.
- R5: Op 4 increments and op 5 decrements A, wrapping at 255/0. The status bits are left unchanged.
- R6: Op 6 (AND), op 7 (OR), op 8 (XOR) of A with opnd, and op 9 (one's complement of A), leave CY, AC and OV unchanged.
- R7: Op 10 rotates A left and op 11 rotates it right, with no flag change. Op 12 rotates left through CY and op 13 rotates right through CY. The bit shifted out goes to CY.
- R8: Op 14 multiplies A by B unsigned. The low byte goes to `res_o` and the high byte to `b_o`. CY is cleared, and OV is set exactly when the product exceeds 255.
- R9: Op 15 divides A by B unsigned. The quotient goes to `res_o` and the remainder to `b_o`, and CY and OV are cleared. When B is zero, OV is set, CY is cleared, and `res_o` and `b_o` are unspecified.
- R10: When `psw_we_i` is high, bits 7:1 of the status byte load `psw_wdata_i` at the clock edge. This write takes precedence over any flag update from the operation in the same cycle.
- R11: `bank_base_o` equals the bank select value times 8: bank 0 to 3 gives 00h, 08h, 10h, 18h.
- R12: Op 0 is a no-operation: `res_o` equals A and the status bits hold. `b_o` equals `b_i` for every op other than 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand |
| b_i | input | 8 | Current B register |
| psw_we_i | input | 1 | Status write enable |
| psw_wdata_i | input | 7 | Status write data for bits 7:1 |
| res_o | output | 8 | New accumulator value |
| b_o | output | 8 | New B register value |
| psw_o | output | 8 | Status byte |
| bank_base_o | output | 5 | Base address of selected register bank |

## Verification
The bench targets several corner cases, and each one exposes a different kind of wrong design:
- Nibble carries on both add and subtract, such as 38h+2Fh with AC set and 88h+93h with AC clear. A design that took AC from the wrong bit, or inverted the borrow sense, would fail these.
- Chains of add-with-carry and subtract-with-borrow, where the stored CY feeds the next result. A flag register that lagged by a cycle would produce off-by-one sums.
- Multiply products either side of 255, and division by zero. These catch a wrong OV decision and a CY left set.
- A status write in the same cycle as an arithmetic op, which shows whether the flag update wrongly wins over the write.
- Zero results with parity clear, which confirm that P follows the accumulator.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBB = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_CPL  = 4'd9,
    OP_RL   = 4'd10,
    OP_RR   = 4'd11,
    OP_RLC  = 4'd12,
    OP_RRC  = 4'd13,
    OP_MUL  = 4'd14,
    OP_DIV  = 4'd15
  } alu_op_e;

  // flag update request from the datapath to the status register
  typedef struct packed {
    logic cy_we;
    logic cy;
    logic ac_we;
    logic ac;
    logic ov_we;
    logic ov;
  } flag_upd_t;

  // status bit positions; decoders outside depend on them
  localparam int unsigned CY_BIT = 7;
  localparam int unsigned AC_BIT = 6;
  localparam int unsigned F0_BIT = 5;
  localparam int unsigned RS_HI  = 4;
  localparam int unsigned RS_LO  = 3;
  localparam int unsigned OV_BIT = 2;
  localparam int unsigned UD_BIT = 1;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic          sub_i,
  input  logic          cin_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o
);
  localparam int unsigned HB  = DW / 2;
  localparam int unsigned MSB = DW - 1;

  logic [DW:0] full;
  logic        c_into_msb;

  always_comb begin
    if (sub_i) full = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
    else       full = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
  end

  assign sum_o = full[DW-1:0];
  assign cy_o  = full[DW];
  // carry/borrow into a bit position is recovered from operands and result
  assign ac_o       = a_i[HB] ^ b_i[HB] ^ full[HB];
  assign c_into_msb = a_i[MSB] ^ b_i[MSB] ^ full[MSB];
  assign ov_o       = c_into_msb ^ full[DW];

endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_we_o,
  output logic          cy_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    res_o   = a_i;
    cy_we_o = 1'b0;
    cy_o    = cy_i;
    unique case (op_i)
      OP_INC: res_o = a_i + ONE;
      OP_DEC: res_o = a_i - ONE;
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_RL:  res_o = {a_i[DW-2:0], a_i[DW-1]};
      OP_RR:  res_o = {a_i[0], a_i[DW-1:1]};
      OP_RLC: begin
        res_o   = {a_i[DW-2:0], cy_i};
        cy_we_o = 1'b1;
        cy_o    = a_i[DW-1];
      end
      OP_RRC: begin
        res_o   = {cy_i, a_i[DW-1:1]};
        cy_we_o = 1'b1;
        cy_o    = a_i[0];
      end
      default: res_o = a_i;
    endcase
  end

endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
  parameter int unsigned DW = 8
) (
  input  logic          div_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic          ov_o
);
  localparam int unsigned PW = 2 * DW;

  logic [PW-1:0] prod;
  logic [DW-1:0] quot;
  logic [DW:0]   rem;
  logic [DW:0]   trial;

  assign prod = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};

  // restoring division, one quotient bit per unrolled step
  always_comb begin
    rem   = '0;
    trial = '0;
    quot  = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      trial = {rem[DW-1:0], a_i[i]};
      if (trial >= {1'b0, b_i}) begin
        rem     = trial - {1'b0, b_i};
        quot[i] = 1'b1;
      end else begin
        rem     = trial;
      end
    end
  end

  always_comb begin
    if (div_i) begin
      lo_o = quot;
      hi_o = rem[DW-1:0];
      ov_o = (b_i == '0);
    end else begin
      lo_o = prod[DW-1:0];
      hi_o = prod[PW-1:DW];
      ov_o = |prod[PW-1:DW];
    end
  end

endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  logic [7:1] wdata_i,
  input  flag_upd_t upd_i,
  output logic [7:1] stat_o
);
  logic [7:1] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (we_i) begin
      stat_d = wdata_i;
    end else begin
      if (upd_i.cy_we) stat_d[CY_BIT] = upd_i.cy;
      if (upd_i.ac_we) stat_d[AC_BIT] = upd_i.ac;
      if (upd_i.ov_we) stat_d[OV_BIT] = upd_i.ov;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] b_i,
  input  logic          psw_we_i,
  input  logic [7:1]    psw_wdata_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] b_o,
  output logic [7:0]    psw_o,
  output logic [4:0]    bank_base_o
);
  alu_op_e       op;
  logic [7:1]    stat;
  logic          cy_cur;

  logic          as_sub, as_cin;
  logic [DW-1:0] as_sum;
  logic          as_cy, as_ac, as_ov;

  logic [DW-1:0] un_res;
  logic          un_cy_we, un_cy;

  logic [DW-1:0] md_lo, md_hi;
  logic          md_ov;

  flag_upd_t     upd;

  assign op     = alu_op_e'(op_i);
  assign cy_cur = stat[CY_BIT];

  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADDC || op == OP_SUBB) ? cy_cur : 1'b0;

  alu8_addsub #(.DW(DW)) u_addsub (
    .sub_i (as_sub),
    .cin_i (as_cin),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sum_o (as_sum),
    .cy_o  (as_cy),
    .ac_o  (as_ac),
    .ov_o  (as_ov)
  );

  alu8_unary #(.DW(DW)) u_unary (
    .op_i    (op),
    .a_i     (acc_i),
    .b_i     (opnd_i),
    .cy_i    (cy_cur),
    .res_o   (un_res),
    .cy_we_o (un_cy_we),
    .cy_o    (un_cy)
  );

  alu8_muldiv #(.DW(DW)) u_muldiv (
    .div_i (op == OP_DIV),
    .a_i   (acc_i),
    .b_i   (b_i),
    .lo_o  (md_lo),
    .hi_o  (md_hi),
    .ov_o  (md_ov)
  );

  always_comb begin
    res_o = acc_i;
    b_o   = b_i;
    upd   = '0;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res_o = as_sum;
        upd   = '{cy_we: 1'b1, cy: as_cy, ac_we: 1'b1, ac: as_ac,
                  ov_we: 1'b1, ov: as_ov};
      end
      OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CPL,
      OP_RL, OP_RR, OP_RLC, OP_RRC: begin
        res_o     = un_res;
        upd.cy_we = un_cy_we;
        upd.cy    = un_cy;
      end
      OP_MUL, OP_DIV: begin
        res_o = md_lo;
        b_o   = md_hi;
        upd   = '{cy_we: 1'b1, cy: 1'b0, ac_we: 1'b0, ac: 1'b0,
                  ov_we: 1'b1, ov: md_ov};
      end
      default: res_o = acc_i;
    endcase
  end

  alu8_status_reg u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (psw_we_i),
    .wdata_i (psw_wdata_i),
    .upd_i   (upd),
    .stat_o  (stat)
  );

  // parity tracks the live accumulator, never stored
  assign psw_o       = {stat, ^acc_i};
  assign bank_base_o = {stat[RS_HI:RS_LO], 3'b000};

endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] b_i,
  input logic          psw_we_i,
  input logic [7:1]    psw_wdata_i,
  input logic [7:0]    psw_o,
  input logic [4:0]    bank_base_o
);

  p_parity_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({acc_i, psw_o[0]}) % 2) == 0);

  p_incdec_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 4'd4 || op_i == 4'd5) && !psw_we_i) |=> $stable(psw_o[7:1]));

  p_logic_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd6 && op_i <= 4'd9 && !psw_we_i) |=> $stable(psw_o[7:1]));

  p_mul_cy_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd14 && !psw_we_i) |=> !psw_o[7]);

  p_div_zero_ov_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd15 && b_i == '0 && !psw_we_i) |=> (psw_o[2] && !psw_o[7]));

  p_sw_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_we_i |=> (psw_o[7:1] == $past(psw_wdata_i)));

  p_bank_base_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_base_o == {psw_o[4:3], 3'b000});

  p_nop_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0 && !psw_we_i) |=> $stable(psw_o[7:1]));

endmodule

bind alu8_status alu8_status_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .acc_i       (acc_i),
  .b_i         (b_i),
  .psw_we_i    (psw_we_i),
  .psw_wdata_i (psw_wdata_i),
  .psw_o       (psw_o),
  .bank_base_o (bank_base_o)
);

// File: tb/sim_alu8_status.sv
`timescale 1ns/1ps
module sim_alu8_status;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0, b_i = '0;
  logic       psw_we_i = 1'b0;
  logic [7:1] psw_wdata_i = '0;
  logic [7:0] res_o, b_o, psw_o;
  logic [4:0] bank_base_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_ps = '0;
  string ptag = "R1";

  always #4 clk_i = ~clk_i;

  alu8_status u0 (
    .clk_i, .rst_ni, .op_i, .acc_i, .opnd_i, .b_i, .psw_we_i,
    .psw_wdata_i, .res_o, .b_o, .psw_o, .bank_base_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic string rtag(input int op);
    case (op)
      0: return "R12";
      1, 2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7, 8, 9: return "R6";
      10, 11, 12, 13: return "R7";
      14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input int op, input int a, input int o, input int b,
                       input logic [7:0] ps, output int r, output int bo,
                       output logic [7:0] nps);
    int c, s, sv;
    nps = ps;
    bo  = b;
    r   = a;
    c   = ps[7];
    case (op)
      1, 2: begin
        if (op == 1) c = 0;
        s = a + o + c;  r = s % 256;
        nps[7] = s > 255;
        nps[6] = (a % 16 + o % 16 + c) > 15;
        sv = sgn(a) + sgn(o) + c;
        nps[2] = (sv > 127) || (sv < -128);
      end
      3: begin
        s = a - o - c;  r = (s + 256) % 256;
        nps[7] = s < 0;
        nps[6] = (a % 16) < (o % 16 + c);
        sv = sgn(a) - sgn(o) - c;
        nps[2] = (sv > 127) || (sv < -128);
      end
      4: r = (a + 1) % 256;
      5: r = (a + 255) % 256;
      6: r = a & o;
      7: r = a | o;
      8: r = a ^ o;
      9: r = 255 - a;
      10: r = (a * 2) % 256 + a / 128;
      11: r = a / 2 + (a % 2) * 128;
      12: begin r = (a * 2) % 256 + c; nps[7] = (a / 128) != 0; end
      13: begin r = a / 2 + c * 128; nps[7] = (a % 2) != 0; end
      14: begin
        s = a * b; r = s % 256; bo = s / 256;
        nps[7] = 0; nps[2] = s > 255;
      end
      15: begin
        nps[7] = 0;
        if (b == 0) nps[2] = 1;
        else begin r = a / b; bo = a % b; nps[2] = 0; end
      end
      default: r = a;
    endcase
  endtask

  task automatic step(input int op, input int a, input int o, input int b,
                      input bit we, input logic [7:1] wd);
    int r, bo;
    logic [7:0] nps;
    @(negedge clk_i);
    chk({ptag, " status"}, int'(psw_o[7:1]), int'(exp_ps[7:1]));
    op_i = op[3:0]; acc_i = a[7:0]; opnd_i = o[7:0]; b_i = b[7:0];
    psw_we_i = we; psw_wdata_i = wd;
    #1;
    model(op, a, o, b, exp_ps, r, bo, nps);
    if (!(op == 15 && b == 0)) begin
      chk({rtag(op), " res"}, int'(res_o), r);
      chk({rtag(op), " b"}, int'(b_o), bo);
    end
    chk("R2 parity", int'(psw_o[0]), int'(^a[7:0]));
    chk("R11 bank", int'(bank_base_o), int'(exp_ps[4:3]) * 8);
    if (we) begin exp_ps = {wd, 1'b0}; ptag = "R10"; end
    else    begin exp_ps = nps;        ptag = rtag(op); end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1 reset", int'(psw_o[7:1]), 0);
    rst_ni = 1'b1;

    // R3 nibble and carry examples
    step(1, 8'h88, 8'h93, 0, 0, '0);
    step(1, 8'h38, 8'h2F, 0, 0, '0);
    step(1, 8'h9C, 8'h64, 0, 0, '0);
    step(0, 8'h00, 0, 0, 0, '0);           // R2 zero acc, P clear
    step(2, 8'hFF, 8'h00, 0, 0, '0);       // R3 carry chain
    // R4 borrow-in via status write of CY
    step(0, 0, 0, 0, 1, 7'b1000000);
    step(3, 8'h50, 8'h20, 0, 0, '0);
    step(3, 8'h80, 8'h01, 0, 0, '0);
    step(3, 8'h00, 8'h01, 0, 0, '0);
    // R7 rotates through carry
    step(12, 8'h81, 0, 0, 0, '0);
    step(13, 8'h02, 0, 0, 0, '0);
    // R8 multiply either side of 255
    step(14, 8'h25, 0, 8'h65, 0, '0);
    step(14, 8'h0F, 0, 8'h11, 0, '0);
    // R9 divide and divide by zero
    step(15, 25, 0, 10, 0, '0);
    step(15, 8'h37, 0, 0, 0, '0);
    // R10 write wins over add flags; R11 bank select; R1 F0 position
    step(1, 8'hFF, 8'hFF, 0, 1, 7'b0010100);
    step(6, 8'hF0, 8'h0F, 0, 0, '0);
    step(0, 0, 0, 0, 1, 7'b0001000);
    step(0, 0, 0, 0, 1, 7'b0011000);
    step(5, 8'h00, 0, 8'h44, 0, '0);       // R5 wrap
    step(4, 8'hFF, 0, 8'h44, 0, '0);

    for (int i = 0; i < 600; i++) begin
      int op, a, o, b;
      bit we;
      op = $urandom % 16;
      a  = $urandom % 256;
      o  = $urandom % 256;
      b  = (($urandom % 16) == 0) ? 0 : $urandom % 256;
      we = ($urandom % 10) == 0;
      step(op, a, o, b, we, 7'($urandom));
    end
    step(0, 0, 0, 0, 0, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule